// File: doc/BRIEF.md
# Read-Level Run-Length Encoder

This block watches a single read-level input and measures, in system clocks, how long that level stays unchanged. Each time the level changes, it latches a compact record into an output register that the host polls. The record holds the run count, the level now on the input, and a ready bit that toggles once per new record. The host detects a fresh record by comparing the ready bit with the value it saw on its last poll, so no strobe has to be caught.

A run longer than the count field can hold is cut into chunks. When the counter reaches the full field range without a level change, a record is emitted anyway. Its level bit is left alone and its ready bit flips, so the count field never wraps silently. An optional external transition pulse can force a record in the same way as a level change. The parameter `RUN_W` sets the width of the count field: 6 by default, or 8 for a wide host bus. The record layout keeps the same shape at either width.

Top module: `runlen_level_enc`

## Requirements
- R1: While reset is high, the record reads count 0 and ready bit 0, its level bit follows `rd_level_i`, and the run counter is cleared.
- R2: The record is `{ready, level, count}`, with the count in bits `[RUN_W-1:0]`, the level in bit `RUN_W` and the ready bit in bit `RUN_W+1`. A latch that comes n clocks after the previous latch records count n. The first latch after reset, n clocks after the last reset clock, records n-1.
- R3: Each latch flips the ready bit exactly once. In a clock with no latch, the whole record holds its value.
- R4: A clock in which `rd_level_i` differs from its value in the previous clock is a transition latch. It loads the level bit from `rd_level_i`.
- R5: When the run counter holds 2^RUN_W (64 at the default width) and no transition occurs, an overflow latch is made. It writes count field 0, which stands for the full range, and leaves the level bit unchanged. The counter never exceeds 2^RUN_W.
- R6: After any latch the counter restarts at 1, counting the latch clock, so no clock is lost between records. Two transitions one clock apart record count 1.
- R7: A transition and an overflow in the same clock make one transition latch. The ready bit flips once, the count field is 0 and the level bit loads the input.
- R8: With `EXT_EDGE` = 1, a high `ext_edge_i` is treated as a transition even when the level has not changed. With `EXT_EDGE` = 0, the pin has no effect on the record.
- R9: With `RUN_W` = 8, the same rules apply with a limit of 256 and a 10-bit record.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| rd_level_i | input | 1 | Read level being measured |
| ext_edge_i | input | 1 | External transition pulse, used when `EXT_EDGE` = 1 |
| rec_o | output | RUN_W+2 | Latched record `{ready, level, count}` |

## Verification
A wrong run counter shows up in the count field of the next record. Because overflow forces a record at least every 2^RUN_W clocks, the error appears within that many clocks. A wrong latch decision appears one clock after the latch clock: either the ready bit fails to flip, or it flips in a clock where the record should have held. A wrong level capture appears in the same record, so both an overflow record that changes the level bit and a transition record that misses the new level are visible at once.

// File: rtl/rle_pkg.sv
package rle_pkg;
  // Run length at which an unbroken run is forced out as a record.
  function automatic int unsigned run_limit(input int unsigned w);
    return 32'd1 << w;
  endfunction

  // Count field value for a run: the full range folds to zero.
  function automatic int unsigned run_field(input int unsigned cnt, input int unsigned w);
    return cnt & ((32'd1 << w) - 32'd1);
  endfunction
endpackage

// File: rtl/rle_edge_detect.sv
module rle_edge_detect #(
  parameter bit EXT_EDGE = 1'b1
) (
  input  logic clk,
  input  logic level_i,
  input  logic ext_i,
  output logic level_change_o,
  output logic ext_hit_o,
  output logic edge_o
);
  logic prev_q;

  always_ff @(posedge clk) begin
    prev_q <= level_i;
  end

  assign level_change_o = level_i ^ prev_q;

  generate
    if (EXT_EDGE) begin : g_ext
      assign ext_hit_o = ext_i;
    end else begin : g_noext
      assign ext_hit_o = 1'b0;
    end
  endgenerate

  assign edge_o = level_change_o | ext_hit_o;
endmodule

// File: rtl/rle_run_counter.sv
module rle_run_counter #(
  parameter int unsigned RUN_W = 6,
  localparam int unsigned CTR_W = RUN_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             latch_i,
  output logic [CTR_W-1:0] cnt_o,
  output logic             full_o
);
  localparam int unsigned LIMIT = rle_pkg::run_limit(RUN_W);

  logic [CTR_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)          cnt_q <= '0;
    else if (latch_i) cnt_q <= CTR_W'(1);
    else              cnt_q <= cnt_q + CTR_W'(1);
  end

  assign cnt_o  = cnt_q;
  assign full_o = (cnt_q == CTR_W'(LIMIT));
endmodule

// File: rtl/rle_record_reg.sv
module rle_record_reg #(
  parameter int unsigned RUN_W = 6,
  localparam int unsigned CTR_W = RUN_W + 1,
  localparam int unsigned REC_W = RUN_W + 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             level_i,
  input  logic             latch_i,
  input  logic             edge_i,
  input  logic [CTR_W-1:0] cnt_i,
  output logic [REC_W-1:0] rec_o
);
  logic [RUN_W-1:0] field_q;
  logic             lvl_q;
  logic             tog_q;
  logic [RUN_W-1:0] field_d;

  assign field_d = RUN_W'(rle_pkg::run_field(32'(cnt_i), RUN_W));

  always_ff @(posedge clk) begin
    if (rst) begin
      field_q <= '0;
      lvl_q   <= level_i;
      tog_q   <= 1'b0;
    end else if (latch_i) begin
      field_q <= field_d;
      tog_q   <= ~tog_q;
      if (edge_i) lvl_q <= level_i;
    end
  end

  assign rec_o = {tog_q, lvl_q, field_q};
endmodule

// File: rtl/runlen_level_enc.sv
module runlen_level_enc #(
  parameter int unsigned RUN_W    = 6,
  parameter bit          EXT_EDGE = 1'b1,
  localparam int unsigned CTR_W   = RUN_W + 1,
  localparam int unsigned REC_W   = RUN_W + 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_level_i,
  input  logic             ext_edge_i,
  output logic [REC_W-1:0] rec_o
);
  // Named internal events, also observed by the bound checker.
  logic             lvl_change;
  logic             ext_hit;
  logic             run_edge;
  logic             run_full;
  logic             latch_ev;
  logic [CTR_W-1:0] run_cnt;

  rle_edge_detect #(.EXT_EDGE(EXT_EDGE)) u_edge (
    .clk           (clk),
    .level_i       (rd_level_i),
    .ext_i         (ext_edge_i),
    .level_change_o(lvl_change),
    .ext_hit_o     (ext_hit),
    .edge_o        (run_edge)
  );

  // A transition and an overflow together form one latch.
  assign latch_ev = run_edge | run_full;

  rle_run_counter #(.RUN_W(RUN_W)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .latch_i(latch_ev),
    .cnt_o  (run_cnt),
    .full_o (run_full)
  );

  rle_record_reg #(.RUN_W(RUN_W)) u_rec (
    .clk    (clk),
    .rst    (rst),
    .level_i(rd_level_i),
    .latch_i(latch_ev),
    .edge_i (run_edge),
    .cnt_i  (run_cnt),
    .rec_o  (rec_o)
  );
endmodule

// File: rtl/runlen_level_enc_chk.sv
module runlen_level_enc_chk #(
  parameter int unsigned RUN_W = 6,
  localparam int unsigned CTR_W = RUN_W + 1,
  localparam int unsigned REC_W = RUN_W + 2
) (
  input logic             clk,
  input logic             rst,
  input logic             rd_level_i,
  input logic [REC_W-1:0] rec_o,
  input logic             run_edge,
  input logic             run_full,
  input logic             latch_ev,
  input logic [CTR_W-1:0] run_cnt
);
  localparam int unsigned LIMIT = rle_pkg::run_limit(RUN_W);

  // R3
  toggle_flip_chk: assert property (@(posedge clk) disable iff (rst)
    latch_ev |=> (rec_o[RUN_W+1] != $past(rec_o[RUN_W+1])));

  // R3
  record_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !latch_ev |=> $stable(rec_o));

  // R4
  level_capture_chk: assert property (@(posedge clk) disable iff (rst)
    run_edge |=> (rec_o[RUN_W] == $past(rd_level_i)));

  // R5
  ovf_level_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (run_full && !run_edge) |=> $stable(rec_o[RUN_W]));

  // R5
  ovf_field_chk: assert property (@(posedge clk) disable iff (rst)
    run_full |=> (rec_o[RUN_W-1:0] == '0));

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    run_cnt <= CTR_W'(LIMIT));

  // R6
  restart_one_chk: assert property (@(posedge clk) disable iff (rst)
    latch_ev |=> (run_cnt == CTR_W'(1)));
endmodule

bind runlen_level_enc runlen_level_enc_chk #(.RUN_W(RUN_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .rd_level_i(rd_level_i),
  .rec_o     (rec_o),
  .run_edge  (run_edge),
  .run_full  (run_full),
  .latch_ev  (latch_ev),
  .run_cnt   (run_cnt)
);

// File: tb/runlen_level_enc_bench.sv
module runlen_level_enc_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lvl = 1'b1;
  logic ext = 1'b0;
  logic [7:0] rec_n;
  logic [9:0] rec_w;

  always #4 clk = ~clk;

  runlen_level_enc #(.RUN_W(6), .EXT_EDGE(1'b1)) u_runlen_level_enc (
    .clk(clk), .rst(rst), .rd_level_i(lvl), .ext_edge_i(ext), .rec_o(rec_n));

  runlen_level_enc #(.RUN_W(8), .EXT_EDGE(1'b0)) u_runlen_level_enc_wide (
    .clk(clk), .rst(rst), .rd_level_i(lvl), .ext_edge_i(ext), .rec_o(rec_w));

  int n_chk = 0;
  int n_fail = 0;
  int simul_hits = 0;
  bit done = 1'b0;

  // Reference state for the narrow and the wide instance.
  int    cnt_n = 0, fld_n = 0, cnt_w = 0, fld_w = 0;
  bit    tog_n = 0, lv_n = 1, prev_n = 1;
  bit    tog_w = 0, lv_w = 1, prev_w = 1;
  string tag_n = "R1", tag_w = "R1";

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Expected record after one clock, written from the requirements.
  task automatic model(input bit ext_en, input int width, input string wide_tag,
                       inout int cnt, inout int fld, inout bit tog, inout bit lv,
                       inout bit prev, output string tag);
    int lim = 1 << width;
    bit changed, forced, full;
    tag = wide_tag;
    if (rst) begin
      cnt = 0; fld = 0; tog = 0; lv = lvl; tag = "R1";
    end else begin
      changed = (lvl != prev);
      forced  = ext_en && ext;
      full    = (cnt == lim);
      if (changed || forced || full) begin
        fld = cnt % lim;
        tog = ~tog;
        if (changed || forced) lv = lvl;
        if (full && (changed || forced)) tag = "R7";
        else if (full)                   tag = "R5";
        else if (forced && !changed)     tag = "R8";
        else if (wide_tag == "")         tag = "R2";
        cnt = 1;
      end else begin
        if (ext && !ext_en) tag = "R8";
        else if (wide_tag == "") tag = "R3";
        cnt = cnt + 1;
      end
    end
    prev = lvl;
  endtask

  task automatic cyc(input bit l, input bit e);
    lvl = l;
    ext = e;
    @(posedge clk);
    model(1'b1, 6, "",   cnt_n, fld_n, tog_n, lv_n, prev_n, tag_n);
    model(1'b0, 8, "R9", cnt_w, fld_w, tog_w, lv_w, prev_w, tag_w);
    if (tag_n == "R7") simul_hits++;
    @(negedge clk);
    chk(tag_n, "count",  int'(rec_n[5:0]), fld_n);
    chk(tag_n, "level",  int'(rec_n[6]),   int'(lv_n));
    chk(tag_n, "toggle", int'(rec_n[7]),   int'(tog_n));
    chk(tag_w, "wide count",  int'(rec_w[7:0]), fld_w);
    chk(tag_w, "wide level",  int'(rec_w[8]),   int'(lv_w));
    chk(tag_w, "wide toggle", int'(rec_w[9]),   int'(tog_w));
  endtask

  task automatic run(input bit l, input int len);
    for (int i = 0; i < len; i++) cyc(l, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    bit l;
    void'($urandom(32'd20250724));
    @(negedge clk);
    rst = 1'b1;
    cyc(1'b1, 1'b0);
    cyc(1'b1, 1'b0);
    // R1: reset state with level high on the input.
    chk("R1", "reset record", int'(rec_n), 8'h40);
    chk("R1", "reset wide record", int'(rec_w), 10'h100);
    rst = 1'b0;
    // R5: long steady run, several forced chunks.
    run(1'b1, 200);
    // R6: two transitions one clock apart.
    cyc(1'b0, 1'b0);
    cyc(1'b1, 1'b0);
    chk("R6", "one-clock run count", int'(rec_n[5:0]), 1);
    // R7: transition in the clock where the counter is full.
    run(1'b1, 63);
    cyc(1'b0, 1'b0);
    chk("R7", "simultaneous count", int'(rec_n[5:0]), 0);
    chk("R7", "simultaneous level", int'(rec_n[6]), 0);
    // R8: external pulse on a steady level.
    run(1'b0, 10);
    cyc(1'b0, 1'b1);
    chk("R8", "ext pulse count", int'(rec_n[5:0]), 11);
    // R9: wide variant over a 300-clock run.
    run(1'b0, 300);
    // Constrained random runs with sparse external pulses.
    l = 1'b1;
    for (int r = 0; r < 1500; r++) begin
      int len = ($urandom % 4 == 0) ? 1 + int'($urandom % 300) : 1 + int'($urandom % 20);
      for (int k = 0; k < len; k++) cyc(l, ($urandom % 32) == 0);
      l = ~l;
      if (r == 700) begin
        rst = 1'b1;
        cyc(l, 1'b0);
        rst = 1'b0;
      end
    end
    chk("R7", "simultaneous events seen", int'(simul_hits > 0), 1);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule